// File: doc/BRIEF.md
# Windowed Interrupt Control Register Bank

This block keeps the per-line enable bits and per-line priority fields for a configurable number of level-sensitive external interrupt lines. It also reports which lines are asserted right now. Software cannot reach arrays this wide through a single 32-bit register, so each access works on one 16-bit window of an array. The window number comes from the low bits of the write data of that same access. No separate index register is kept, so an interrupt handler has no index state to save or restore.

A register access presents an access strobe, a write qualifier, a two-bit array select and 32-bit write data. The read data is combinational and shows the selected window as it stood before the access. A write lands on the next clock edge. The complete enable, pending and priority vectors are driven out in parallel for a downstream interrupt selector.

Top module: `irq_window_bank`

## Requirements
- R1: The bank serves `NUM_IRQ` lines (at most 512), each with one enable bit on `irq_enable` and one pending bit on `irq_pending`. `irq_pending` follows `irq_in` in the same cycle.
- R2: For array select 0 (enable) or 1 (pending), `rdata[31:16]` carries the window picked by `wdata[4:0]`. Bit 16+b of that window is line 16*index+b.
- R3: An access with `wr_en` low uses window 0, whatever `wdata` holds.
- R4: An enable write (`acc_en`, `wr_en`, select 0) stores `wdata[31:16]` into the selected enable window. All other enable bits keep their value. No enable bit changes without such a write.
- R5: After reset, every enable bit and every priority field is 0.
- R6: The pending array is read-only. A write with select 1 changes no enable bit, no priority field and no pending bit.
- R7: For select 2 (priority), `wdata[6:0]` picks a window of four 4-bit fields. Window w covers lines 4w to 4w+3, and line 4w+k sits at `rdata[19+4k:16+4k]`. A priority write stores each field from the matching write-data bits. Line i's field also appears at `irq_prio[4i+3:4i]`.
- R8: With `PRIO_BITS` below 4, the low 4-PRIO_BITS bits of every priority field read as 0, and writes to them have no effect.
- R9: `rdata[15:0]` is always 0. `rdata` is 0 when `acc_en` is low or the select is 3. An access with select 3, or with `acc_en` low, changes nothing.
- R10: A window past the last configured line, and any bit position above the last line inside a partial window, reads as 0 and ignores writes.
- R11: A read-modify-write access returns the old window contents. The new contents show on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_en | input | 1 | Register access strobe |
| wr_en | input | 1 | Access performs a write |
| arr_sel | input | 2 | Array select: 0 enable, 1 pending, 2 priority, 3 none |
| wdata | input | 32 | Write data: window contents in 31:16, window index in the low bits |
| irq_in | input | NUM_IRQ | Raw level-sensitive interrupt lines |
| rdata | output | 32 | Read data, window in 31:16 |
| irq_enable | output | NUM_IRQ | Full enable vector |
| irq_pending | output | NUM_IRQ | Full pending vector |
| irq_prio | output | 4*NUM_IRQ | Full priority vector, 4 bits per line |

## Verification
A bad enable or priority register shows up in two places. It appears on the parallel output vectors in the cycle after the faulty write. It also appears in `rdata` on the next access to that window. A wrong window decode is caught the same way: it either corrupts a neighbouring window or leaves the target unchanged. Writes aimed at the partial window, at windows past the last line and at the read-only pending array are all followed by checks on the full output vectors. This exposes any state those writes touch within one cycle.

// File: rtl/irq_win_pkg.sv
package irq_win_pkg;
  localparam int MAX_IRQ  = 512;
  localparam int FIELD_W  = 4;
  localparam int WIN_W    = 16;
  localparam int PAD_EN_W = MAX_IRQ;
  localparam int PAD_PR_W = MAX_IRQ * FIELD_W;

  typedef enum logic [1:0] {
    SEL_ENABLE  = 2'd0,
    SEL_PENDING = 2'd1,
    SEL_PRIO    = 2'd2,
    SEL_NONE    = 2'd3
  } arr_sel_e;

  // Bits of a window (lines_per_bit lines per bit) that map onto existing lines.
  function automatic logic [WIN_W-1:0] live_bits(input int unsigned idx,
                                                 input int unsigned num_irq);
    logic [WIN_W-1:0] v;
    for (int b = 0; b < WIN_W; b++)
      v[b] = ((idx * WIN_W + b) < num_irq);
    return v;
  endfunction

  // Implemented bits of one priority field: the top PRIO_BITS of FIELD_W.
  function automatic logic [FIELD_W-1:0] prio_keep(input int unsigned bits);
    return 4'hF << (FIELD_W - bits);
  endfunction
endpackage

// File: rtl/irq_win_decode.sv
module irq_win_decode
  import irq_win_pkg::*;
(
  input  logic       acc_en,
  input  logic       wr_en,
  input  logic [1:0] arr_sel,
  input  logic [6:0] idx_bits,
  output logic [6:0] win_idx,
  output logic       en_wr,
  output logic       prio_wr,
  output logic       rd_en,
  output logic       rd_pend,
  output logic       rd_prio
);
  logic wr_act;

  always_comb begin
    wr_act  = acc_en && wr_en;
    rd_en   = acc_en && (arr_sel == SEL_ENABLE);
    rd_pend = acc_en && (arr_sel == SEL_PENDING);
    rd_prio = acc_en && (arr_sel == SEL_PRIO);
    en_wr   = wr_act && (arr_sel == SEL_ENABLE);
    prio_wr = wr_act && (arr_sel == SEL_PRIO);
    if (!wr_act)
      win_idx = '0;
    else if (arr_sel == SEL_PRIO)
      win_idx = idx_bits;
    else
      win_idx = {2'b00, idx_bits[4:0]};
  end
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank
  import irq_win_pkg::*;
#(
  parameter int NUM_IRQ = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [4:0]         win_idx,
  input  logic [WIN_W-1:0]   wdata_hi,
  output logic [NUM_IRQ-1:0] en_q
);
  logic [PAD_EN_W-1:0] en_pad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr) begin
      for (int i = 0; i < NUM_IRQ; i++)
        if (win_idx == 5'(i / WIN_W))
          en_q[i] <= wdata_hi[i % WIN_W];
    end
  end

  assign en_pad = PAD_EN_W'(en_q);

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(en_q)); // R4

  AST_EN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (en_pad[int'($past(win_idx))*WIN_W +: WIN_W] ==
            ($past(wdata_hi) & live_bits($past(win_idx), NUM_IRQ)))); // R10
endmodule

// File: rtl/irq_prio_bank.sv
module irq_prio_bank
  import irq_win_pkg::*;
#(
  parameter int NUM_IRQ   = 40,
  parameter int PRIO_BITS = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [6:0]                 win_idx,
  input  logic [WIN_W-1:0]           wdata_hi,
  output logic [NUM_IRQ*FIELD_W-1:0] prio_flat
);
  localparam logic [FIELD_W-1:0] KEEP = prio_keep(PRIO_BITS);
  localparam int FIELDS_PER_WIN = WIN_W / FIELD_W;

  logic [NUM_IRQ-1:0][FIELD_W-1:0] prio_q;
  logic lsb_leak;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
    end else if (wr) begin
      for (int i = 0; i < NUM_IRQ; i++)
        if (win_idx == 7'(i / FIELDS_PER_WIN))
          prio_q[i] <= wdata_hi[(i % FIELDS_PER_WIN)*FIELD_W +: FIELD_W] & KEEP;
    end
  end

  assign prio_flat = prio_q;
  assign lsb_leak  = |(prio_flat & {NUM_IRQ{~KEEP}});

  AST_PRIO_LSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !lsb_leak); // R8

  AST_PRIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(prio_flat)); // R7
endmodule

// File: rtl/irq_window_bank.sv
module irq_window_bank
  import irq_win_pkg::*;
#(
  parameter int NUM_IRQ   = 40,
  parameter int PRIO_BITS = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc_en,
  input  logic                       wr_en,
  input  logic [1:0]                 arr_sel,
  input  logic [31:0]                wdata,
  input  logic [NUM_IRQ-1:0]         irq_in,
  output logic [31:0]                rdata,
  output logic [NUM_IRQ-1:0]         irq_enable,
  output logic [NUM_IRQ-1:0]         irq_pending,
  output logic [NUM_IRQ*FIELD_W-1:0] irq_prio
);
  logic [6:0] win_idx;
  logic       en_wr, prio_wr, rd_en, rd_pend, rd_prio;
  logic [PAD_EN_W-1:0] en_pad, pend_pad;
  logic [PAD_PR_W-1:0] prio_pad;
  logic [WIN_W-1:0]    win_val;

  irq_win_decode u_dec (
    .acc_en  (acc_en),
    .wr_en   (wr_en),
    .arr_sel (arr_sel),
    .idx_bits(wdata[6:0]),
    .win_idx (win_idx),
    .en_wr   (en_wr),
    .prio_wr (prio_wr),
    .rd_en   (rd_en),
    .rd_pend (rd_pend),
    .rd_prio (rd_prio)
  );

  irq_enable_bank #(.NUM_IRQ(NUM_IRQ)) u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (en_wr),
    .win_idx (win_idx[4:0]),
    .wdata_hi(wdata[31:16]),
    .en_q    (irq_enable)
  );

  irq_prio_bank #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_pr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (prio_wr),
    .win_idx  (win_idx),
    .wdata_hi (wdata[31:16]),
    .prio_flat(irq_prio)
  );

  assign irq_pending = irq_in;
  assign en_pad      = PAD_EN_W'(irq_enable);
  assign pend_pad    = PAD_EN_W'(irq_in);
  assign prio_pad    = PAD_PR_W'(irq_prio);

  always_comb begin
    win_val = '0;
    if (rd_en)   win_val = en_pad[int'(win_idx[4:0])*WIN_W +: WIN_W];
    if (rd_pend) win_val = pend_pad[int'(win_idx[4:0])*WIN_W +: WIN_W];
    if (rd_prio) win_val = prio_pad[int'(win_idx)*WIN_W +: WIN_W];
    rdata = {win_val, 16'h0000};
  end

  initial begin
    AST_IRQ_COUNT: assert (NUM_IRQ >= 1 && NUM_IRQ <= MAX_IRQ &&
                           PRIO_BITS >= 1 && PRIO_BITS <= FIELD_W); // R1
  end

  AST_LOW_HALF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[15:0] == 16'h0000); // R9

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_en || arr_sel == SEL_NONE) |-> rdata == 32'h0); // R9

  AST_READ_WIN0: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !wr_en && arr_sel == SEL_ENABLE) |->
      rdata[31:16] == (16'(irq_enable) & live_bits(0, NUM_IRQ))); // R3

  AST_PEND_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && arr_sel == SEL_PENDING) |=>
      ($stable(irq_enable) && $stable(irq_prio))); // R6
endmodule

// File: tb/irq_window_bank_test.sv
module irq_window_bank_test;
  localparam int N  = 40;
  localparam int PW = N * 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_en = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    arr_sel = 2'd0;
  logic [31:0]   wdata = 32'h0;
  logic [N-1:0]  irq_in = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  irq_enable;
  logic [N-1:0]  irq_pending;
  logic [PW-1:0] irq_prio;

  int n_chk  = 0;
  int n_fail = 0;

  irq_window_bank #(.NUM_IRQ(N), .PRIO_BITS(3)) uut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .wr_en(wr_en),
    .arr_sel(arr_sel), .wdata(wdata), .irq_in(irq_in), .rdata(rdata),
    .irq_enable(irq_enable), .irq_pending(irq_pending), .irq_prio(irq_prio)
  );

  always #4 clk = ~clk;

  task automatic chk(input logic [PW-1:0] act, input logic [PW-1:0] exp,
                     input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One access: read data sampled before the edge, state settles after it.
  task automatic acc(input logic [1:0] sel, input logic wr, input logic [31:0] d,
                     output logic [31:0] rd);
    @(negedge clk);
    acc_en = 1'b1; wr_en = wr; arr_sel = sel; wdata = d;
    #1 rd = rdata;
    @(posedge clk);
    #1 acc_en = 1'b0; wr_en = 1'b0; wdata = 32'h0;
  endtask

  task automatic t_reset;
    chk(PW'(irq_enable), '0, "R5 enables after reset");
    chk(irq_prio, '0, "R5 priorities after reset");
    chk(PW'(rdata), '0, "R9 idle read data");
  endtask

  task automatic t_enable;
    logic [31:0] rd;
    acc(2'd0, 1'b1, 32'hA5C3_0000, rd);
    chk(PW'(rd), '0, "R11 old window on write");
    chk(PW'(irq_enable[15:0]), PW'(16'hA5C3), "R4 enable window 0 stored");
    acc(2'd0, 1'b0, 32'hFFFF_0002, rd);
    chk(PW'(rd), PW'(32'hA5C3_0000), "R3 no-write access reads window 0");
    chk(PW'(irq_enable), PW'(40'h00_0000_A5C3), "R4 read leaves enables");
    acc(2'd0, 1'b1, 32'hFFFF_0002, rd);
    chk(PW'(rd), '0, "R2 window 2 old value");
    chk(PW'(irq_enable), PW'(40'hFF_0000_A5C3), "R10 partial window write");
    acc(2'd0, 1'b1, 32'h0000_0002, rd);
    chk(PW'(rd), PW'(32'h00FF_0000), "R11 partial window readback");
    chk(PW'(irq_enable), PW'(40'h00_0000_A5C3), "R4 window 2 cleared");
    acc(2'd0, 1'b1, 32'hFFFF_001F, rd);
    chk(PW'(rd), '0, "R10 far window reads 0");
    chk(PW'(irq_enable), PW'(40'h00_0000_A5C3), "R10 far window ignored");
    @(negedge clk);
    wr_en = 1'b1; wdata = 32'hFFFF_0000;
    #1 chk(PW'(rdata), '0, "R9 no strobe reads 0");
    @(posedge clk);
    #1 wr_en = 1'b0; wdata = 32'h0;
    chk(PW'(irq_enable), PW'(40'h00_0000_A5C3), "R4 no strobe no write");
  endtask

  task automatic t_pending;
    logic [31:0] rd;
    @(negedge clk);
    irq_in = 40'h12_0000_BEEF;
    #1 chk(PW'(irq_pending), PW'(40'h12_0000_BEEF), "R1 pending follows lines");
    acc(2'd1, 1'b0, 32'h0000_0002, rd);
    chk(PW'(rd), PW'(32'hBEEF_0000), "R2 pending window 0");
    acc(2'd1, 1'b1, 32'hFFFF_0002, rd);
    chk(PW'(rd), PW'(32'h0012_0000), "R2 pending partial window");
    chk(PW'(irq_pending), PW'(40'h12_0000_BEEF), "R6 pending not written");
    chk(PW'(irq_enable), PW'(40'h00_0000_A5C3), "R6 enables untouched");
    chk(irq_prio, '0, "R6 priorities untouched");
    @(negedge clk);
    irq_in = 40'h00_5A5A_0000;
    acc(2'd1, 1'b1, 32'h0000_0001, rd);
    chk(PW'(rd), PW'(32'h5A5A_0000), "R2 pending window 1");
  endtask

  task automatic t_prio;
    logic [31:0] rd;
    acc(2'd2, 1'b1, 32'hFFFF_0003, rd);
    chk(PW'(rd), '0, "R11 priority old window");
    chk(irq_prio, PW'(16'hEEEE) << 48, "R8 low bit dropped lines 12-15");
    acc(2'd2, 1'b1, 32'h1234_0009, rd);
    chk(irq_prio, (PW'(16'hEEEE) << 48) | (PW'(16'h0224) << 144),
        "R7 field order window 9");
    acc(2'd2, 1'b0, 32'h0000_0009, rd);
    chk(PW'(rd), '0, "R3 priority no-write reads window 0");
    acc(2'd2, 1'b1, 32'h0000_0009, rd);
    chk(PW'(rd), PW'(32'h0224_0000), "R11 priority readback");
    chk(irq_prio, PW'(16'hEEEE) << 48, "R7 window 9 cleared");
    acc(2'd2, 1'b1, 32'hFFFF_000A, rd);
    chk(PW'(rd), '0, "R10 priority far window reads 0");
    chk(irq_prio, PW'(16'hEEEE) << 48, "R10 priority far window ignored");
  endtask

  task automatic t_none;
    logic [31:0] rd;
    acc(2'd3, 1'b1, 32'hFFFF_0000, rd);
    chk(PW'(rd), '0, "R9 select 3 reads 0");
    chk(PW'(irq_enable), PW'(40'h00_0000_A5C3), "R9 select 3 enables kept");
    chk(irq_prio, PW'(16'hEEEE) << 48, "R9 select 3 priorities kept");
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_enable();
    t_pending();
    t_prio();
    t_none();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule